// File: doc/BRIEF.md
# Adaptive Dual-to-Triple Redundancy Controller

This block runs three identical copies of a small accumulator datapath and chooses how many of them take part in producing the result. In its resting mode two copies are clocked and compared on every cycle. The third copy is a spare, and its clock is stopped by a latch-based gate, so the spare draws no switching power while the pair agrees. The visible output follows copy 0.

When the two active copies disagree, the block raises a one-cycle fault pulse and marks that cycle's output as unreliable. It restarts the spare's clock and loads the spare's state from copy 0, so the spare joins the others already aligned. From the next cycle on, the output is a bitwise majority of all three copies. Once a programmable number of consecutive cycles pass with all three in agreement, the block stops the spare's clock again and returns to the dual mode.

Each copy holds a running sum of the input word. A per-copy upset port flips chosen bits of that copy's output word. These upsets model transient faults for testing and leave the stored state untouched.

Top module: `dmr_tmr_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, data_o is 0, triple_o is 0, fault_o is 0, unreliable_o is 0 and outvoted_o is 0. All three copies restart from a sum of 0.
- R2: Each copy's state becomes state + data_i on every clock it receives. In dual mode (triple_o = 0), data_o equals copy 0's state XOR its upset mask, where copy k is upset when upset_en_i[k] = 1 using upset_mask_i.
- R3: In dual mode, any bit difference between the outputs of copy 0 and copy 1 drives fault_o and unreliable_o high in that same cycle. It also makes triple_o read 1 from the next cycle on.
- R4: On waking, the spare (copy 2) is loaded with copy 0's state plus that cycle's data_i. On the first triple cycle its output therefore matches the correct sum, so an upset on copy 1 in that cycle is outvoted.
- R5: In triple mode, data_o is the bitwise majority of the three copy outputs. When two copies are upset on the same bit, that bit follows them.
- R6: In triple mode, any disagreement among the three outputs drives fault_o high for that cycle. It sets outvoted_o[k] for every copy k whose output differs from the vote, and the bit stays set until reset. unreliable_o stays 0 in triple mode.
- R7: Triple mode lasts until HOLD_CYCLES consecutive cycles pass without disagreement. triple_o then reads 0 from the following cycle. A disagreement restarts the count.
- R8: In dual mode the spare receives no clock, and an upset on copy 2 has no effect on data_o, fault_o, unreliable_o or triple_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | WIDTH | Word added to every clocked copy's sum |
| upset_en_i | input | 3 | Per-copy transient upset enable, bit k for copy k |
| upset_mask_i | input | WIDTH | Bits flipped in each upset copy's output |
| data_o | output | WIDTH | Copy 0 in dual mode, majority vote in triple mode |
| triple_o | output | 1 | 1 while in triple mode |
| fault_o | output | 1 | One-cycle pulse on a detected disagreement |
| unreliable_o | output | 1 | data_o in this cycle came from an unconfirmed dual mismatch |
| outvoted_o | output | 3 | Sticky record of copies overruled by the vote |

## Verification
A behavioural model tracks the true running sum and the mode counter, and it is compared with every output on each cycle. Clean dual-mode traffic confirms the accumulation and that copy 0 drives the output. Upsets on the sleeping spare confirm that an unclocked copy cannot disturb the result. A copy 0 upset followed by a copy 1 upset on the wake cycle tells a properly resynchronised spare apart from a stale one. Overlapping two-copy upsets separate a bitwise vote from a whole-word vote. Quiet runs with an interruption just before the exit point check that the hold counter restarts.

// File: rtl/dmr_tmr_pkg.sv
package dmr_tmr_pkg;
  typedef enum logic {
    MODE_DUAL   = 1'b0,
    MODE_TRIPLE = 1'b1
  } mode_e;
endpackage

// File: rtl/dmr_tmr_clk_gate.sv
// Latch-based stoppable clock: enable captured while clk is low.
module dmr_tmr_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/dmr_tmr_copy.sv
module dmr_tmr_copy #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_base_i,
  input  logic [WIDTH-1:0] upset_i,
  output logic [WIDTH-1:0] state_o,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= (load_i ? load_base_i : state_q) + data_i;
  end

  assign state_o = state_q;
  assign out_o   = state_q ^ upset_i;
endmodule

// File: rtl/dmr_tmr_voter.sv
module dmr_tmr_voter #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] vote_o,
  output logic [2:0]       lose_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign vote_o[i] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
  end

  assign lose_o = {c_i != vote_o, b_i != vote_o, a_i != vote_o};
endmodule

// File: rtl/dmr_tmr_ctrl.sv
module dmr_tmr_ctrl
  import dmr_tmr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int HOLD_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic [2:0]       upset_en_i,
  input  logic [WIDTH-1:0] upset_mask_i,
  output logic [WIDTH-1:0] data_o,
  output logic             triple_o,
  output logic             fault_o,
  output logic             unreliable_o,
  output logic [2:0]       outvoted_o
);
  localparam int NCOPY = 3;
  localparam int CW    = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  mode_e            mode_q;
  logic [CW-1:0]    quiet_q;
  logic [2:0]       outvoted_q;
  logic [WIDTH-1:0] st  [NCOPY];
  logic [WIDTH-1:0] out [NCOPY];
  logic [WIDTH-1:0] vote;
  logic [2:0]       lose;
  logic             triple_q, mismatch, wake, disagree, spare_en, spare_clk;

  assign triple_q = (mode_q == MODE_TRIPLE);
  assign mismatch = (out[0] != out[1]);
  assign wake     = !triple_q && mismatch;
  assign disagree = triple_q && (lose != 3'b000);
  assign spare_en = triple_q || wake;

  dmr_tmr_clk_gate u_gate (
    .clk_i  (clk_i),
    .en_i   (spare_en),
    .gclk_o (spare_clk)
  );

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    localparam bit SPARE = (k == NCOPY - 1);
    dmr_tmr_copy #(.WIDTH(WIDTH)) u_copy (
      .clk_i       (SPARE ? spare_clk : clk_i),
      .rst_ni      (rst_ni),
      .data_i      (data_i),
      .load_i      (SPARE ? wake : 1'b0),
      .load_base_i (st[0]),
      .upset_i     (upset_en_i[k] ? upset_mask_i : '0),
      .state_o     (st[k]),
      .out_o       (out[k])
    );
  end

  dmr_tmr_voter #(.WIDTH(WIDTH)) u_voter (
    .a_i    (out[0]),
    .b_i    (out[1]),
    .c_i    (out[2]),
    .vote_o (vote),
    .lose_o (lose)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_DUAL;
      quiet_q    <= '0;
      outvoted_q <= '0;
    end else if (!triple_q) begin
      quiet_q <= '0;
      if (wake) mode_q <= MODE_TRIPLE;
    end else if (disagree) begin
      quiet_q    <= '0;
      outvoted_q <= outvoted_q | lose;
    end else if (quiet_q == LAST) begin
      quiet_q <= '0;
      mode_q  <= MODE_DUAL;
    end else begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assign data_o       = triple_q ? vote : out[0];
  assign triple_o     = triple_q;
  assign fault_o      = wake || disagree;
  assign unreliable_o = wake;
  assign outvoted_o   = outvoted_q;

  assert_wake_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!triple_q && mismatch) |=> triple_q);

  assert_resync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(triple_q) |-> (st[2] == st[0]));

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((outvoted_q & $past(outvoted_q)) == $past(outvoted_q)));

  assert_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triple_q && !disagree && quiet_q == LAST) |=> !triple_q);

  assert_asleep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!triple_q && !mismatch) |=> $stable(st[2]));
endmodule

// File: tb/dmr_tmr_ctrl_tb_top.sv
`timescale 1ns/1ps
module dmr_tmr_ctrl_tb_top;
  localparam int W    = 8;
  localparam int HOLD = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [2:0]   upset_en_i = '0;
  logic [W-1:0] upset_mask_i = '0;
  logic [W-1:0] data_o;
  logic         triple_o, fault_o, unreliable_o;
  logic [2:0]   outvoted_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int     m_sum = 0;
  bit     m_triple = 0;
  int     m_quiet = 0;
  bit [2:0] m_outv = '0;

  always #2 clk_i = ~clk_i;

  dmr_tmr_ctrl #(.WIDTH(W), .HOLD_CYCLES(HOLD)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .upset_en_i(upset_en_i), .upset_mask_i(upset_mask_i),
    .data_o(data_o), .triple_o(triple_o), .fault_o(fault_o),
    .unreliable_o(unreliable_o), .outvoted_o(outvoted_o)
  );

  task automatic compare(string req, logic [W-1:0] e_d, bit e_t, bit e_f, bit e_u, bit [2:0] e_v);
    checks++;
    if (data_o !== e_d || triple_o !== e_t || fault_o !== e_f ||
        unreliable_o !== e_u || outvoted_o !== e_v) begin
      fails++;
      $display("FAIL %s: got d=%h t=%b f=%b u=%b v=%b, expected d=%h t=%b f=%b u=%b v=%b",
               req, data_o, triple_o, fault_o, unreliable_o, outvoted_o,
               e_d, e_t, e_f, e_u, e_v);
    end
  endtask

  task automatic step(string req, logic [W-1:0] d, logic [2:0] en, logic [W-1:0] mask);
    logic [W-1:0] o [3];
    logic [W-1:0] e_d;
    bit           dis, mm;
    bit [2:0]     lose;
    @(negedge clk_i);
    data_i = d; upset_en_i = en; upset_mask_i = mask;
    #1;
    for (int k = 0; k < 3; k++) o[k] = W'(m_sum) ^ (en[k] ? mask : '0);
    mm = (o[0] != o[1]);
    dis = 0; lose = '0;
    if (!m_triple) begin
      e_d = o[0];
      compare(req, e_d, 0, mm, mm, m_outv);
    end else begin
      for (int b = 0; b < W; b++) begin
        int n = 0;
        for (int k = 0; k < 3; k++) n += o[k][b];
        e_d[b] = (n >= 2);
      end
      for (int k = 0; k < 3; k++) lose[k] = (o[k] != e_d);
      dis = (lose != 0);
      compare(req, e_d, 1, dis, 0, m_outv);
    end
    @(posedge clk_i);
    if (!m_triple) begin
      if (mm) begin m_triple = 1; m_quiet = 0; end
    end else if (dis) begin
      m_quiet = 0; m_outv |= lose;
    end else if (m_quiet == HOLD - 1) begin
      m_triple = 0; m_quiet = 0;
    end else m_quiet++;
    m_sum = (m_sum + d) % (1 << W);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; data_i = '0; upset_en_i = '0; upset_mask_i = '0;
    #1;
    compare("R1 in reset", '0, 0, 0, 0, 3'b000);
    m_sum = 0; m_triple = 0; m_quiet = 0; m_outv = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #80000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    do_reset();
    step("R1 after reset", 8'h11, 3'b000, '0);
    // R2: plain dual accumulation
    step("R2", 8'h22, 3'b000, '0);
    step("R2", 8'hF0, 3'b000, '0);
    step("R2", 8'h7F, 3'b000, '0);
    step("R2", 8'h01, 3'b000, '0);
    // R8: spare upsets ignored while asleep
    step("R8", 8'h05, 3'b100, 8'hFF);
    step("R8", 8'h09, 3'b100, 8'h3C);
    step("R2", 8'h00, 3'b000, '0);
    // R3: copy 0 upset forces wake
    step("R3", 8'h13, 3'b001, 8'h01);
    // R4: copy 1 upset on first triple cycle must be outvoted by resynced spare
    step("R4", 8'h07, 3'b010, 8'hF0);
    // R7: quiet count interrupted one cycle before exit
    step("R7", 8'h02, 3'b000, '0);
    step("R7", 8'h03, 3'b000, '0);
    step("R7", 8'h04, 3'b000, '0);
    step("R6", 8'h05, 3'b100, 8'h81);
    for (int i = 0; i < HOLD; i++) step("R7", 8'(i + 6), 3'b000, '0);
    step("R7 back to dual", 8'h21, 3'b000, '0);
    step("R2", 8'h44, 3'b000, '0);
    // R5: overlapping two-copy upsets in triple
    step("R3", 8'h10, 3'b010, 8'h08);
    step("R5", 8'h11, 3'b011, 8'h0F);
    step("R5", 8'h12, 3'b101, 8'h3C);
    step("R6", 8'h13, 3'b001, 8'h40);
    for (int i = 0; i < HOLD + 2; i++) step("R7", 8'(3 * i), 3'b000, '0);
    step("R8", 8'h55, 3'b100, 8'h0F);
    step("R3", 8'h66, 3'b011, 8'h0F);
    step("R3", 8'h77, 3'b001, 8'h01);
    step("R5", 8'h88, 3'b110, 8'hA5);
    for (int i = 0; i < HOLD + 1; i++) step("R7", 8'hC1, 3'b000, '0);
    // R1: reset mid-run clears sticky bits and sum
    do_reset();
    step("R1 after reset", 8'h01, 3'b000, '0);
    step("R2", 8'h02, 3'b000, '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule